// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models the slave end of a two-wire serial EEPROM at bit level. On every clock it takes one sample of the clock line and one of the data line, as a host sees them after writing. From these samples it finds start and stop conditions and counts clock-line periods inside a transfer. It collects the command, address and write bits into an internal byte array, and it returns read bits, acknowledge bits or the host's own level on `sda_out`.

A static `mode` input picks one of three framings. The first is a 1-Kbit part whose first byte holds a 7-bit word address and the read/write flag. The second is a part with a device-select byte followed by one word-address byte. The third is a part with a device-select byte followed by two word-address bytes. All of them are driven by one cycle counter, whose wrap points set the acknowledge slots and the byte loops of sequential access.

The line samples are plain level inputs rather than a stream. A sample is taken every clock and never refused, so there is no valid/ready pair and no back-pressure. The host paces the transfer by how long it holds each level.

Top module: `eep_slave`

## Requirements
- R1: A start condition is a sample where the clock line is high now and was high on the previous sample, while the data line goes from 1 to 0. It opens a transfer and sets the cycle count to 0. The held word address is kept, so a repeated start can begin a read at the address set just before it, and a start in the middle of a byte restarts the framing.
- R2: A stop condition is a sample where the clock line is high now and was high on the previous sample, while the data line goes from 0 to 1. It closes the transfer, including one cut off in the middle of a byte. After it, `sda_out` follows the host's data level, and the next transfer is framed afresh.
- R3: In an open transfer, each rising clock edge advances the count and each falling edge takes the current data level as the next input bit. The slave drives `sda_out` to 0 in acknowledge slots: count 9 in mode 0, and counts 9, 18 and 27 in modes 1 and 2.
- R4: In mode 0, the first byte (counts 1 to 8, MSB first) is the word address in bits 7:1 and the read flag in bit 0, where 1 means read. In write transfers, counts 10 to 17 shift a data byte, MSB first, into the addressed location.
- R5: In a mode 0 write, each finished data byte increments only address bits 1:0, so writes wrap inside an aligned 4-byte page.
- R6: In a mode 0 read, after each byte the count goes from 18 back to 9 and the word address goes up by one, wrapping from 127 to 0.
- R7: In mode 1 (code 1), counts 1 to 8 carry a device-select byte whose bit 0 is the read flag. Counts 10 to 17 carry the word address. When that address is complete, device-select bits 3:1 become address bits 10:8. Write data starts at count 19.
- R8: In writes in modes 1 and 2, each finished data byte increments only address bits 3:0 (a 16-byte page). The count loops from 27 to 18 in mode 1 and from 36 to 27 in mode 2.
- R9: In reads in modes 1 and 2, data is returned MSB first in counts 10 to 17. After each byte the count goes back to 9 and the full address goes up by one, crossing page boundaries.
- R10: In mode 2 (codes 2 and 3), counts 10 to 17 and 19 to 26 carry the high and then the low address byte. The address is held to 13 bits, and write data starts at count 28.
- R11: With no open transfer, and outside acknowledge slots and read data counts, `sda_out` equals the last sampled host data level.
- R12: The bit for the next count appears on `sda_out` one clock after the falling clock sample, so the host may read it while the clock line is still low. It holds its value through the high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Framing: 0 one-byte command, 1 one-byte address, 2 or 3 two-byte address |
| scl_in | input | 1 | Sampled host clock-line level |
| sda_in | input | 1 | Sampled host data-line level |
| sda_out | output | 1 | Data-line level returned to the host |

## Verification
The hardest state to reach from the pins is a read that has to carry across a boundary. The 1-Kbit address must roll from 127 to 0, and in the wider modes a page must be crossed. Both need a set of earlier writes to known locations, done in a fixed order, and the page-wrap property of writes is used to place one of those bytes. The bench does this as a bit-banged master. It first writes the bytes on both sides of the boundary in separate transfers, and then sets the pointer with a write header and a repeated start. It also cuts transfers off mid-byte with a start or a stop, and then shows that the next transfer is framed correctly.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int CYC_W  = 6;
  localparam int ADDR_W = 13;

  typedef enum logic [1:0] {
    EEP_SMALL = 2'd0,
    EEP_SHORT = 2'd1,
    EEP_LONG  = 2'd2
  } eep_mode_e;

  // Next value of the cycle counter on a rising clock-line edge.
  function automatic logic [CYC_W-1:0] cyc_step(input logic [1:0] m,
                                                input logic [CYC_W-1:0] c,
                                                input logic rd);
    logic [CYC_W-1:0] n;
    n = c + 1'b1;
    if (m == EEP_SMALL) begin
      if (n == 6'd18) n = 6'd9;
    end else if (rd && n == 6'd18) begin
      n = 6'd9;
    end else if (m == EEP_SHORT && n == 6'd27) begin
      n = 6'd18;
    end else if (n == 6'd36) begin
      n = 6'd27;
    end
    return n;
  endfunction
endpackage

// File: rtl/eep_link.sv
module eep_link
  import eep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             rd,
  output logic             scl_q,
  output logic             sda_q,
  output logic             started,
  output logic [CYC_W-1:0] cyc,
  output logic [CYC_W-1:0] eff_cyc,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic both_hi, start_ev, stop_ev;

  assign both_hi  = scl_q & scl_in;
  assign start_ev = both_hi & sda_q & ~sda_in;
  assign stop_ev  = both_hi & ~sda_q & sda_in;
  assign rise_ev  = started & ~scl_q & scl_in;
  assign fall_ev  = started & scl_q & ~scl_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      started <= 1'b0;
      cyc     <= '0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (start_ev) begin
        started <= 1'b1;
        cyc     <= '0;
      end else if (stop_ev) begin
        started <= 1'b0;
      end else if (rise_ev) begin
        cyc <= cyc_step(mode, cyc, rd);
      end
    end
  end

  // While the clock line is low the next cycle is already decided.
  assign eff_cyc = scl_q ? cyc : cyc_step(mode, cyc, rd);
endmodule

// File: rtl/eep_shift.sv
module eep_shift
  import eep_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              sda_in,
  input  logic [CYC_W-1:0]  cyc,
  input  logic              rise_ev,
  input  logic              fall_ev,
  output logic              rd,
  output logic              wr_en,
  output logic [MEM_AW-1:0] idx
);
  logic [ADDR_W-1:0] addr;
  logic [3:0]        dev_lo;
  logic              small_m, short_m, is_ack, in_data;
  logic [ADDR_W-1:0] sh;

  assign small_m = (mode == EEP_SMALL);
  assign short_m = (mode == EEP_SHORT);
  assign rd      = small_m ? addr[0] : dev_lo[0];
  assign idx     = small_m ? MEM_AW'(addr[7:1]) : addr[MEM_AW-1:0];
  assign is_ack  = (cyc == 6'd9) || (cyc == 6'd18) || (cyc == 6'd27);
  assign in_data = short_m ? (cyc > 6'd18) : (cyc > 6'd27);

  always_comb begin
    if (small_m)
      wr_en = fall_ev && (cyc > 6'd9) && !addr[0];
    else
      wr_en = fall_ev && !is_ack && in_data && !dev_lo[0];
  end

  always_comb begin
    sh = {addr[ADDR_W-2:0], sda_in};
    if (short_m) begin
      sh[ADDR_W-1:8] = '0;
      if (cyc == 6'd17) sh[10:8] = dev_lo[3:1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      dev_lo <= '0;
    end else if (rise_ev && cyc == 6'd17 && rd) begin
      if (small_m) addr[7:1] <= addr[7:1] + 1'b1;
      else         addr      <= addr + 1'b1;
    end else if (fall_ev) begin
      if (small_m) begin
        if (cyc < 6'd9)
          addr <= {{(ADDR_W-8){1'b0}}, addr[6:0], sda_in};
        else if (cyc == 6'd17 && !addr[0])
          addr[2:1] <= addr[2:1] + 1'b1;
      end else if (!is_ack) begin
        if (in_data) begin
          if (!dev_lo[0] && (cyc == 6'd26 || cyc == 6'd35))
            addr[3:0] <= addr[3:0] + 1'b1;
        end else if (cyc > 6'd9) begin
          if (!dev_lo[0]) addr <= sh;
        end else begin
          dev_lo <= {dev_lo[2:0], sda_in};
        end
      end
    end
  end
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] idx,
  input  logic              bit_in,
  output logic [7:0]        byte_out
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= {mem[idx][6:0], bit_in};
  end

  assign byte_out = mem[idx];
endmodule

// File: rtl/eep_slave.sv
module eep_slave
  import eep_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_out
);
  logic             scl_q, sda_q, started, rise_ev, fall_ev, rd, wr_en;
  logic [CYC_W-1:0] cyc, eff_cyc;
  logic [MEM_AW-1:0] idx;
  logic [7:0]       byte_out;
  logic [2:0]       bit_sel;
  logic             ack_slot, in_win;

  eep_link link_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .scl_in(scl_in), .sda_in(sda_in),
    .rd(rd), .scl_q(scl_q), .sda_q(sda_q), .started(started), .cyc(cyc),
    .eff_cyc(eff_cyc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  eep_shift #(.MEM_AW(MEM_AW)) shift_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sda_in(sda_in), .cyc(cyc),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .rd(rd), .wr_en(wr_en), .idx(idx)
  );

  eep_store #(.MEM_AW(MEM_AW)) store_i (
    .clk(clk), .wr_en(wr_en), .idx(idx), .bit_in(sda_in), .byte_out(byte_out)
  );

  assign ack_slot = (eff_cyc == 6'd9) ||
                    ((mode != EEP_SMALL) && (eff_cyc == 6'd18 || eff_cyc == 6'd27));
  assign in_win   = rd && (eff_cyc >= 6'd10) && (eff_cyc <= 6'd17);
  assign bit_sel  = 3'(6'd17 - eff_cyc);

  always_comb begin
    if (!started)      sda_out = sda_q;
    else if (ack_slot) sda_out = 1'b0;
    else if (in_win)   sda_out = byte_out[bit_sel];
    else               sda_out = sda_q;
  end
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       scl_in,
  input logic       sda_in,
  input logic       sda_out,
  input logic       started,
  input logic [5:0] cyc,
  input logic [5:0] eff_cyc
);
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(scl_in) && scl_in && $past(sda_in) && !sda_in)
      |=> (started && cyc == 6'd0));

  a_r2_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(scl_in) && scl_in && !$past(sda_in) && sda_in)
      |=> !started);

  a_r3_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
    (started && (eff_cyc == 6'd9 ||
                 (mode != 2'd0 && (eff_cyc == 6'd18 || eff_cyc == 6'd27))))
      |-> !sda_out);

  a_r11_open_bus: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !started) |-> (sda_out == $past(sda_in)));

  a_r6_small_loop: assert property (@(posedge clk) disable iff (!rst_n)
    (started && mode == 2'd0) |-> (cyc <= 6'd17));

  a_r8_wide_loop: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (cyc <= 6'd35));
endmodule

bind eep_slave eep_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .scl_in(scl_in), .sda_in(sda_in),
  .sda_out(sda_out), .started(started), .cyc(cyc), .eff_cyc(eff_cyc)
);

// File: tb/eep_slave_tb_top.sv
module eep_slave_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic       sda_o;
  int         checks = 0;
  int         errs = 0;
  bit         done = 1'b0;

  eep_slave dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .scl_in(scl), .sda_in(sda), .sda_out(sda_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Set both lines at a falling clock, let the design see them, sample at a falling clock.
  task automatic lines(input logic s, input logic d);
    @(negedge clk);
    scl = s;
    sda = d;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_start();
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    lines(1'b1, 1'b0);
    lines(1'b0, 1'b0);
  endtask

  task automatic bus_stop();
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);
  endtask

  task automatic send_bit(input logic b);
    lines(1'b0, b);
    lines(1'b1, b);
    lines(1'b0, b);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [7:0] echo;
    for (int i = 7; i >= 0; i--) begin
      lines(1'b0, b[i]);
      lines(1'b1, b[i]);
      echo[i] = sda_o;
      lines(1'b0, b[i]);
    end
    chk("R11 host level echoed while sending", {24'd0, echo}, {24'd0, b});
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    chk("R3 slave acknowledge", {31'd0, sda_o}, 32'd0);
    lines(1'b0, 1'b1);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] val);
    logic [7:0] lo, hi;
    for (int i = 7; i >= 0; i--) begin
      lines(1'b0, 1'b1);
      lo[i] = sda_o;
      lines(1'b1, 1'b1);
      hi[i] = sda_o;
      lines(1'b0, 1'b1);
    end
    chk("R12 bit valid while clock low", {24'd0, lo}, {24'd0, hi});
    lines(1'b0, nack);
    lines(1'b1, nack);
    lines(1'b0, nack);
    val = hi;
  endtask

  task automatic set_ptr(input logic [7:0] dev, input logic [15:0] addr);
    bus_start();
    send_byte(dev);
    if (mode[1]) send_byte(addr[15:8]);
    send_byte(addr[7:0]);
  endtask

  task automatic wide_wr(input logic [7:0] dev, input logic [15:0] addr,
                         input logic [31:0] data, input int n);
    set_ptr(dev, addr);
    for (int k = 0; k < n; k++) send_byte(data[8*k +: 8]);
    bus_stop();
  endtask

  task automatic wide_rd(input logic [7:0] dev, input logic [15:0] addr,
                         input int n, output logic [31:0] got);
    logic [7:0] v;
    got = '0;
    set_ptr(dev, addr);
    bus_start();
    send_byte(dev | 8'h01);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, v);
      got[8*k +: 8] = v;
    end
    bus_stop();
  endtask

  task automatic small_wr(input logic [6:0] word, input logic [31:0] data, input int n);
    bus_start();
    send_byte({word, 1'b0});
    for (int k = 0; k < n; k++) send_byte(data[8*k +: 8]);
    bus_stop();
  endtask

  task automatic small_rd(input logic [6:0] word, input int n, output logic [31:0] got);
    logic [7:0] v;
    got = '0;
    bus_start();
    send_byte({word, 1'b1});
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, v);
      got[8*k +: 8] = v;
    end
    bus_stop();
  endtask

  task automatic t_idle();
    chk("R11 idle after reset", {31'd0, sda_o}, 32'd1);
    lines(1'b0, 1'b1);
    lines(1'b0, 1'b0);
    chk("R11 idle follows host low", {31'd0, sda_o}, 32'd0);
    lines(1'b0, 1'b1);
    chk("R11 idle follows host high", {31'd0, sda_o}, 32'd1);
    lines(1'b1, 1'b1);
  endtask

  task automatic t_small();
    logic [31:0] got;
    mode = 2'd0;
    small_wr(7'h05, 32'hA3A2A1A0, 4);
    small_rd(7'h04, 4, got);
    chk("R5 R4 four-byte page wrap", got, 32'hA2A1A0A3);
    small_wr(7'h7F, 32'h0000005A, 1);
    small_wr(7'h00, 32'h000000C3, 1);
    small_rd(7'h7F, 2, got);
    chk("R6 read address wraps 127 to 0", got, 32'h0000C35A);
  endtask

  task automatic t_short();
    logic [31:0] got;
    mode = 2'd1;
    wide_wr(8'hA0, 16'h000E, 32'h00000099, 1);
    wide_wr(8'hA4, 16'h0010, 32'h00000044, 1);
    wide_wr(8'hA4, 16'h000E, 32'h00332211, 3);
    wide_rd(8'hA4, 16'h000E, 3, got);
    chk("R9 R1 sequential read crosses page", got, 32'h00442211);
    wide_rd(8'hA4, 16'h0000, 1, got);
    chk("R8 sixteen-byte page wrap", got, 32'h00000033);
    wide_rd(8'hA0, 16'h000E, 1, got);
    chk("R7 select bits pick the block", got, 32'h00000099);
  endtask

  task automatic t_long();
    logic [31:0] got;
    mode = 2'd2;
    wide_wr(8'hA0, 16'h1240, 32'h00000077, 1);
    wide_wr(8'hA0, 16'h123F, 32'h0000ADDE, 2);
    wide_rd(8'hA0, 16'h123F, 2, got);
    chk("R9 R10 two-byte address sequential read", got, 32'h000077DE);
    wide_rd(8'hA0, 16'hF230, 1, got);
    chk("R10 R8 address held to 13 bits, page wrap", got, 32'h000000AD);
  endtask

  task automatic t_abort();
    logic [31:0] got;
    mode = 2'd1;
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    wide_rd(8'hA4, 16'h000E, 1, got);
    chk("R1 start mid-byte restarts framing", got, 32'h00000011);
    bus_start();
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_stop();
    lines(1'b0, 1'b1);
    lines(1'b0, 1'b0);
    chk("R2 after stop follows host low", {31'd0, sda_o}, 32'd0);
    lines(1'b0, 1'b1);
    chk("R2 after stop follows host high", {31'd0, sda_o}, 32'd1);
    lines(1'b1, 1'b1);
    wide_rd(8'hA4, 16'h000F, 1, got);
    chk("R2 transfer after stop framed afresh", got, 32'h00000022);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_idle();
    t_small();
    t_short();
    t_long();
    t_abort();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog R1 actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule